// File: doc/BRIEF.md
# Ethernet MAC Flow Control Unit

This block decides when a 10/100 Ethernet MAC must throttle its link partner or itself. On a full-duplex link it asks the transmit path for pause frames, either because software forced one through a control register or because the receive buffer crossed a water mark. It also holds the transmitter back while a pause time received from the partner is still running. On a half-duplex link it asks the transmit path to send a jam pattern when a frame starts to arrive while the receive buffer is too full to take it. The jam can be raised for any frame, or only for frames whose destination address matched.

Frame building, CRC and the MAC state machines are outside the block. A pause request is a level `pause_req` with a 16-bit `pause_time`, held until the MAC pulses `pause_ack`. A jam request is a level `jam_req`, held until `jam_ack`. Software reaches an 8-bit control/status register through a write strobe and a combinational read bus.

Four state machines make up the block. The pause requester has `PS_IDLE` and `PS_WAIT`. It moves `PS_IDLE -> PS_WAIT` when any source is pending and `PS_WAIT -> PS_IDLE` on `pause_ack`. The water-mark tracker has `WM_BELOW` and `WM_ABOVE`. It moves `WM_BELOW -> WM_ABOVE` when the fill reaches the high mark and `WM_ABOVE -> WM_BELOW` when the fill falls to the low mark. When automatic pause is off or the link is half duplex, it is forced to `WM_BELOW`. The jam controller has `JM_IDLE` and `JM_JAM`. It moves `JM_IDLE -> JM_JAM` on a qualifying frame start and `JM_JAM -> JM_IDLE` on `jam_ack`. The receive pause timer has `RT_IDLE` and `RT_COUNT`. A received nonzero time takes it to `RT_COUNT`, and a received time of zero takes it to `RT_IDLE`. It moves `RT_COUNT -> RT_IDLE` when the last quantum tick brings the count to zero.

Top module: `eth_fc_unit`

## Requirements
- R1: After reset `pause_req`, `jam_req`, `tx_inhibit` and all bits of `cfg_rdata` are 0.
- R2: Writing 1 to register bit 7 requests a pause frame with `pause_time` 0x0000. Bit 7 reads 1 until that request is acknowledged and reads 0 afterwards. Writing 0 to bit 7 does not cancel the request.
- R3: Writing 1 to register bit 6 requests a pause frame with `pause_time` 0xFFFF. Bit 6 reads 1 until that request is acknowledged and reads 0 afterwards.
- R4: When bits 6 and 7 are both pending, the 0xFFFF request is issued first. The 0x0000 request follows after the first is acknowledged.
- R5: `pause_req` and `pause_time` stay unchanged until `pause_ack`. Only one request is outstanding at a time, and every request matches a cause.
- R6: With bit 5 set and `full_duplex` high, a fill rising to at least PAUSE_HI gives exactly one request of 0xFFFF. A later fall to at most PAUSE_LO gives exactly one request of 0x0000. With bit 5 clear, or on a half-duplex link, the fill never causes a request.
- R7: With bit 4 set and `full_duplex` low, a `rx_frame_start` while the fill is strictly above BP_HI raises `jam_req` in the next cycle. `jam_req` is held until `jam_ack`. No jam is raised when the fill is at or below BP_HI.
- R8: With only bit 3 set, the jam of R7 is raised only when `rx_da_match` is high together with `rx_frame_start`.
- R9: No jam is raised on a full-duplex link.
- R10: On a full-duplex link `rx_pause_valid` sets register bit 2. Writing 1 to bit 2 clears it, and writing 0 to bit 2 leaves it set. Received pause frames on a half-duplex link change neither bit 2 nor bit 1.
- R11: A received pause time loads the timer. The timer drops by one per `quanta_tick`. Register bit 1 reads 1 exactly while the timer is nonzero, and a received time of 0 leaves bit 1 at 0.
- R12: `tx_inhibit` is high exactly when register bit 0 is set and the timer is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| full_duplex | input | 1 | Link is full duplex |
| fill_level | input | FILL_W | Receive buffer fill level |
| rx_frame_start | input | 1 | A frame begins to arrive |
| rx_da_match | input | 1 | Destination address matched, valid with frame start |
| rx_pause_valid | input | 1 | A pause frame was received |
| rx_pause_time | input | 16 | Pause time carried by the received frame |
| quanta_tick | input | 1 | One pause quantum (512 bit times) elapsed |
| pause_req | output | 1 | Pause frame request to the transmit path |
| pause_time | output | 16 | Time value for the requested pause frame |
| pause_ack | input | 1 | Transmit path finished the pause frame |
| jam_req | output | 1 | Jam request to the transmit path |
| jam_ack | input | 1 | Jam sent |
| tx_inhibit | output | 1 | Hold the transmitter |

## Verification
The hardest situation to reach is a pause request that stays outstanding while new causes arrive behind it. Later force writes must then wait and come out in priority order, and none may be lost or merged. The bench withholds the acknowledge and writes both force bits one after the other. It checks the held request cycle by cycle, then releases the acknowledge and lets the scoreboard confirm the order 0xFFFF then 0x0000. Water-mark hysteresis is reached by walking the fill through levels between the marks, and the scoreboard flags any request that no cause explains.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int PT_W = 16;
    typedef logic [PT_W-1:0] ptime_t;
    localparam ptime_t PT_XOFF = '1;
    localparam ptime_t PT_XON  = '0;

    // control/status register bit positions
    localparam int B_FCEN  = 0;
    localparam int B_BUSY  = 1;
    localparam int B_LATCH = 2;
    localparam int B_BPDA  = 3;
    localparam int B_BPALL = 4;
    localparam int B_PEN   = 5;
    localparam int B_FHI   = 6;
    localparam int B_FLO   = 7;

    typedef enum logic [1:0] {SRC_NONE, SRC_FHI, SRC_FLO, SRC_AUTO} psrc_t;
endpackage

// File: rtl/fc_regs.sv
module fc_regs
    import fc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       done_hi,
    input  logic       done_lo,
    input  logic       rx_seen,
    input  logic       timer_busy,
    output logic       fc_en,
    output logic       bp_da,
    output logic       bp_all,
    output logic       pause_en,
    output logic       force_hi,
    output logic       force_lo
);
    logic rx_latch;
    logic unused_ro_bit;
    assign unused_ro_bit = cfg_wdata[B_BUSY];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_en    <= 1'b0;
            bp_da    <= 1'b0;
            bp_all   <= 1'b0;
            pause_en <= 1'b0;
            force_hi <= 1'b0;
            force_lo <= 1'b0;
            rx_latch <= 1'b0;
        end else begin
            if (cfg_we) begin
                fc_en    <= cfg_wdata[B_FCEN];
                bp_da    <= cfg_wdata[B_BPDA];
                bp_all   <= cfg_wdata[B_BPALL];
                pause_en <= cfg_wdata[B_PEN];
            end
            // a new write of 1 wins over the completion that clears it
            if (cfg_we && cfg_wdata[B_FHI])
                force_hi <= 1'b1;
            else if (done_hi)
                force_hi <= 1'b0;
            if (cfg_we && cfg_wdata[B_FLO])
                force_lo <= 1'b1;
            else if (done_lo)
                force_lo <= 1'b0;
            // a receive event wins over a write-one clear
            if (rx_seen)
                rx_latch <= 1'b1;
            else if (cfg_we && cfg_wdata[B_LATCH])
                rx_latch <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata          = '0;
        cfg_rdata[B_FCEN]  = fc_en;
        cfg_rdata[B_BUSY]  = timer_busy;
        cfg_rdata[B_LATCH] = rx_latch;
        cfg_rdata[B_BPDA]  = bp_da;
        cfg_rdata[B_BPALL] = bp_all;
        cfg_rdata[B_PEN]   = pause_en;
        cfg_rdata[B_FHI]   = force_hi;
        cfg_rdata[B_FLO]   = force_lo;
    end

    // R10: a receive event is visible in the status bit on the next cycle
    a_r10_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_seen |=> cfg_rdata[B_LATCH]);
    // R2: a pending zero-time force survives until its completion
    a_r2_force_held: assert property (@(posedge clk) disable iff (!rst_n)
        force_lo && !done_lo |=> force_lo);
endmodule

// File: rtl/fc_water.sv
module fc_water
    import fc_pkg::*;
#(
    parameter int FILL_W   = 8,
    parameter int PAUSE_HI = 192,
    parameter int PAUSE_LO = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [FILL_W-1:0] fill,
    input  logic              take,
    output logic              pend,
    output ptime_t            ptime
);
    localparam logic [FILL_W-1:0] HI_L = FILL_W'(PAUSE_HI);
    localparam logic [FILL_W-1:0] LO_L = FILL_W'(PAUSE_LO);

    typedef enum logic {WM_BELOW, WM_ABOVE} wm_state_t;
    wm_state_t state, nxt;

    always_comb begin
        nxt = state;
        if (!enable)
            nxt = WM_BELOW;
        else begin
            unique case (state)
                WM_BELOW: if (fill >= HI_L) nxt = WM_ABOVE;
                WM_ABOVE: if (fill <= LO_L) nxt = WM_BELOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WM_BELOW;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            ptime <= PT_XON;
        end else if (!enable) begin
            pend <= 1'b0;
        end else if (state != nxt) begin
            pend  <= 1'b1;
            ptime <= (nxt == WM_ABOVE) ? PT_XOFF : PT_XON;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    // R6: a new crossing carries the time matching the side it went to
    a_r6_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> ((ptime == PT_XOFF) == (state == WM_ABOVE)));
endmodule

// File: rtl/fc_pause_tx.sv
module fc_pause_tx
    import fc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   force_hi,
    input  logic   force_lo,
    input  logic   auto_pend,
    input  ptime_t auto_time,
    input  logic   pause_ack,
    output logic   pause_req,
    output ptime_t pause_time,
    output logic   done_hi,
    output logic   done_lo,
    output logic   auto_take
);
    typedef enum logic {PS_IDLE, PS_WAIT} ps_state_t;
    ps_state_t state, nxt;
    psrc_t     sel, cur_src;

    always_comb begin
        if (force_hi)       sel = SRC_FHI;
        else if (force_lo)  sel = SRC_FLO;
        else if (auto_pend) sel = SRC_AUTO;
        else                sel = SRC_NONE;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_IDLE: if (sel != SRC_NONE) nxt = PS_WAIT;
            PS_WAIT: if (pause_ack)       nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src    <= SRC_NONE;
            pause_time <= PT_XON;
        end else if (state == PS_IDLE && nxt == PS_WAIT) begin
            cur_src <= sel;
            unique case (sel)
                SRC_FHI:  pause_time <= PT_XOFF;
                SRC_FLO:  pause_time <= PT_XON;
                SRC_AUTO: pause_time <= auto_time;
                SRC_NONE: pause_time <= pause_time;
            endcase
        end
    end

    assign pause_req = (state == PS_WAIT);
    assign auto_take = (state == PS_IDLE) && (sel == SRC_AUTO);
    assign done_hi   = (state == PS_WAIT) && pause_ack && (cur_src == SRC_FHI);
    assign done_lo   = (state == PS_WAIT) && pause_ack && (cur_src == SRC_FLO);

    // R5: an outstanding request keeps its value until acknowledged
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack |=> pause_req && $stable(pause_time));
    // R4: with both forces pending the all-ones time goes first
    a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_req && force_hi && force_lo |=> pause_req && pause_time == PT_XOFF);
endmodule

// File: rtl/fc_jam.sv
module fc_jam #(
    parameter int FILL_W = 8,
    parameter int BP_HI  = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_duplex,
    input  logic              frame_start,
    input  logic              da_match,
    input  logic [FILL_W-1:0] fill,
    input  logic              bp_all,
    input  logic              bp_da,
    input  logic              jam_ack,
    output logic              jam_req
);
    localparam logic [FILL_W-1:0] BP_L = FILL_W'(BP_HI);

    typedef enum logic {JM_IDLE, JM_JAM} jm_state_t;
    jm_state_t state, nxt;
    logic      hit;

    assign hit = !full_duplex && frame_start && (fill > BP_L) &&
                 (bp_all || (bp_da && da_match));

    always_comb begin
        nxt = state;
        unique case (state)
            JM_IDLE: if (hit)     nxt = JM_JAM;
            JM_JAM:  if (jam_ack) nxt = JM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= JM_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) jam_req <= 1'b0;
        else        jam_req <= (nxt == JM_JAM);
    end

    // R9: a jam only starts from a half-duplex frame start
    a_r9_half_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> $past(!full_duplex && frame_start));
    // R7: the jam request is held until acknowledged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        jam_req && !jam_ack |=> jam_req);
endmodule

// File: rtl/fc_rx_pause.sv
module fc_rx_pause
    import fc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   full_duplex,
    input  logic   rx_pause_valid,
    input  ptime_t rx_pause_time,
    input  logic   quanta_tick,
    output logic   busy,
    output logic   rx_seen
);
    typedef enum logic {RT_IDLE, RT_COUNT} rt_state_t;
    rt_state_t state, nxt;
    ptime_t    timer;
    logic      load;

    assign load    = full_duplex && rx_pause_valid;
    assign rx_seen = load;

    always_comb begin
        nxt = state;
        if (load)
            nxt = (rx_pause_time != '0) ? RT_COUNT : RT_IDLE;
        else begin
            unique case (state)
                RT_IDLE:  nxt = RT_IDLE;
                RT_COUNT: if (quanta_tick && timer == ptime_t'(1)) nxt = RT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RT_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            timer <= '0;
        else if (load)
            timer <= rx_pause_time;
        else if (state == RT_COUNT && quanta_tick)
            timer <= timer - 1'b1;
    end

    assign busy = (state == RT_COUNT);

    // R11: a running timer drops by exactly one per quantum
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy && quanta_tick && !load |=> timer == $past(timer) - 1'b1);
    // R11: the busy flag agrees with a nonzero count
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (timer != '0));
endmodule

// File: rtl/eth_fc_unit.sv
module eth_fc_unit
    import fc_pkg::*;
#(
    parameter int FILL_W   = 8,
    parameter int PAUSE_HI = 192,
    parameter int PAUSE_LO = 64,
    parameter int BP_HI    = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              full_duplex,
    input  logic [FILL_W-1:0] fill_level,
    input  logic              rx_frame_start,
    input  logic              rx_da_match,
    input  logic              rx_pause_valid,
    input  logic [15:0]       rx_pause_time,
    input  logic              quanta_tick,
    output logic              pause_req,
    output logic [15:0]       pause_time,
    input  logic              pause_ack,
    output logic              jam_req,
    input  logic              jam_ack,
    output logic              tx_inhibit
);
    logic   fc_en, bp_da, bp_all, pause_en, force_hi, force_lo;
    logic   done_hi, done_lo, rx_seen, timer_busy;
    logic   auto_pend, auto_take;
    ptime_t auto_time;

    fc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .done_hi(done_hi), .done_lo(done_lo),
        .rx_seen(rx_seen), .timer_busy(timer_busy), .fc_en(fc_en),
        .bp_da(bp_da), .bp_all(bp_all), .pause_en(pause_en),
        .force_hi(force_hi), .force_lo(force_lo)
    );

    fc_water #(.FILL_W(FILL_W), .PAUSE_HI(PAUSE_HI), .PAUSE_LO(PAUSE_LO)) u_water (
        .clk(clk), .rst_n(rst_n), .enable(pause_en && full_duplex),
        .fill(fill_level), .take(auto_take), .pend(auto_pend), .ptime(auto_time)
    );

    fc_pause_tx u_ptx (
        .clk(clk), .rst_n(rst_n), .force_hi(force_hi), .force_lo(force_lo),
        .auto_pend(auto_pend), .auto_time(auto_time), .pause_ack(pause_ack),
        .pause_req(pause_req), .pause_time(pause_time), .done_hi(done_hi),
        .done_lo(done_lo), .auto_take(auto_take)
    );

    fc_jam #(.FILL_W(FILL_W), .BP_HI(BP_HI)) u_jam (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .frame_start(rx_frame_start), .da_match(rx_da_match), .fill(fill_level),
        .bp_all(bp_all), .bp_da(bp_da), .jam_ack(jam_ack), .jam_req(jam_req)
    );

    fc_rx_pause u_rxp (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .rx_pause_valid(rx_pause_valid), .rx_pause_time(rx_pause_time),
        .quanta_tick(quanta_tick), .busy(timer_busy), .rx_seen(rx_seen)
    );

    assign tx_inhibit = fc_en && timer_busy;

    // R12: the inhibit is seen only with enable and a running timer on the read bus
    a_r12_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inhibit |-> cfg_rdata[B_FCEN] && cfg_rdata[B_BUSY]);
endmodule

// File: tb/sim_eth_fc_unit.sv
module sim_eth_fc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        full_duplex = 1'b1;
    logic [7:0]  fill_level = 8'd100;
    logic        rx_frame_start = 1'b0, rx_da_match = 1'b0;
    logic        rx_pause_valid = 1'b0;
    logic [15:0] rx_pause_time = '0;
    logic        quanta_tick = 1'b0;
    logic        pause_req, jam_req, tx_inhibit;
    logic [15:0] pause_time;
    logic        pause_ack = 1'b0;
    logic        jam_ack = 1'b0;

    int checks = 0, errors = 0, req_cnt = 0;
    bit ack_en = 1'b1;
    bit done = 1'b0;
    logic [7:0] cfg = '0;

    typedef struct { logic [15:0] t; string tag; } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    eth_fc_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .full_duplex(full_duplex), .fill_level(fill_level),
        .rx_frame_start(rx_frame_start), .rx_da_match(rx_da_match),
        .rx_pause_valid(rx_pause_valid), .rx_pause_time(rx_pause_time),
        .quanta_tick(quanta_tick), .pause_req(pause_req), .pause_time(pause_time),
        .pause_ack(pause_ack), .jam_req(jam_req), .jam_ack(jam_ack),
        .tx_inhibit(tx_inhibit)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic push(input logic [15:0] t, input string tag);
        exp_t e;
        e.t = t;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic jam_frame(input bit da, input bit expv, input string tag);
        @(negedge clk);
        rx_frame_start = 1'b1;
        rx_da_match = da;
        @(negedge clk);
        rx_frame_start = 1'b0;
        rx_da_match = 1'b0;
        chk(jam_req == expv, tag, jam_req, expv);
        if (expv) begin
            idle(2);
            chk(jam_req == 1'b1, {tag, " held"}, jam_req, 1);
            jam_ack = 1'b1;
            @(negedge clk);
            jam_ack = 1'b0;
            chk(jam_req == 1'b0, {tag, " released"}, jam_req, 0);
        end
    endtask

    task automatic rx_pause(input logic [15:0] t);
        @(negedge clk);
        rx_pause_valid = 1'b1;
        rx_pause_time = t;
        @(negedge clk);
        rx_pause_valid = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        quanta_tick = 1'b1;
        @(negedge clk);
        quanta_tick = 1'b0;
    endtask

    // monitor: acts as the transmit path and scores each pause request
    always @(negedge clk) begin
        exp_t e;
        if (pause_ack)
            pause_ack = 1'b0;
        else if (rst_n && pause_req && ack_en) begin
            req_cnt++;
            if (exp_q.size() == 0)
                chk(1'b0, "R5 unexpected request", pause_time, 32'hx);
            else begin
                e = exp_q.pop_front();
                chk(pause_time == e.t, e.tag, pause_time, e.t);
            end
            pause_ack = 1'b1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_sim();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cfg_rdata == 8'h00, "R1 rdata", cfg_rdata, 0);
        chk({pause_req, jam_req, tx_inhibit} == 3'b000, "R1 outputs",
            {pause_req, jam_req, tx_inhibit}, 0);

        // R3
        push(16'hFFFF, "R3 time");
        wr(cfg | 8'h40);
        chk(cfg_rdata[6] == 1'b1, "R3 bit pending", cfg_rdata[6], 1);
        idle(4);
        chk(cfg_rdata[6] == 1'b0, "R3 self clear", cfg_rdata[6], 0);

        // R2
        push(16'h0000, "R2 time");
        wr(cfg | 8'h80);
        chk(cfg_rdata[7] == 1'b1, "R2 bit pending", cfg_rdata[7], 1);
        idle(4);
        chk(cfg_rdata[7] == 1'b0, "R2 self clear", cfg_rdata[7], 0);

        // R4
        push(16'hFFFF, "R4 first");
        push(16'h0000, "R4 second");
        wr(cfg | 8'hC0);
        chk(cfg_rdata[7:6] == 2'b11, "R4 both pending", cfg_rdata[7:6], 3);
        idle(2);
        chk(cfg_rdata[7:6] == 2'b10, "R4 hi served first", cfg_rdata[7:6], 2);
        idle(4);
        chk(cfg_rdata[7:6] == 2'b00, "R4 both served", cfg_rdata[7:6], 0);

        // R5: hold without ack while a second force queues; R2 write-0 keeps it
        ack_en = 1'b0;
        push(16'hFFFF, "R5 held value");
        push(16'h0000, "R5 queued value");
        wr(cfg | 8'h40);
        wr(cfg | 8'h80);
        wr(cfg);
        chk(cfg_rdata[7] == 1'b1, "R2 write zero keeps", cfg_rdata[7], 1);
        for (int i = 0; i < 4; i++) begin
            chk(pause_req && pause_time == 16'hFFFF, "R5 hold",
                {pause_req, pause_time}, {1'b1, 16'hFFFF});
            @(negedge clk);
        end
        ack_en = 1'b1;
        idle(8);
        chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);

        // R6: water marks, full duplex
        cfg = 8'h20;
        wr(cfg);
        n = req_cnt;
        push(16'hFFFF, "R6 high crossing");
        fill_level = 8'd200;
        idle(6);
        fill_level = 8'd150;
        idle(6);
        fill_level = 8'd220;
        idle(6);
        chk(req_cnt == n + 1, "R6 one request above", req_cnt, n + 1);
        push(16'h0000, "R6 low crossing");
        fill_level = 8'd50;
        idle(6);
        fill_level = 8'd30;
        idle(6);
        chk(req_cnt == n + 2, "R6 one request below", req_cnt, n + 2);
        full_duplex = 1'b0;
        fill_level = 8'd200;
        idle(6);
        fill_level = 8'd50;
        idle(6);
        chk(req_cnt == n + 2, "R6 none in half duplex", req_cnt, n + 2);
        full_duplex = 1'b1;
        cfg = 8'h00;
        wr(cfg);
        fill_level = 8'd200;
        idle(6);
        fill_level = 8'd50;
        idle(6);
        chk(req_cnt == n + 2, "R6 none when disabled", req_cnt, n + 2);

        // R7
        full_duplex = 1'b0;
        cfg = 8'h10;
        wr(cfg);
        fill_level = 8'd170;
        jam_frame(1'b0, 1'b1, "R7 jam above mark");
        fill_level = 8'd160;
        jam_frame(1'b0, 1'b0, "R7 no jam at mark");
        fill_level = 8'd120;
        jam_frame(1'b1, 1'b0, "R7 no jam below mark");

        // R8
        cfg = 8'h08;
        wr(cfg);
        fill_level = 8'd170;
        jam_frame(1'b1, 1'b1, "R8 jam on match");
        jam_frame(1'b0, 1'b0, "R8 no jam without match");

        // R9
        cfg = 8'h18;
        wr(cfg);
        full_duplex = 1'b1;
        jam_frame(1'b1, 1'b0, "R9 no jam full duplex");
        fill_level = 8'd100;

        // R10, R11, R12
        cfg = 8'h01;
        wr(cfg);
        rx_pause(16'd3);
        chk(cfg_rdata[2:1] == 2'b11, "R10 latch and R11 busy", cfg_rdata[2:1], 3);
        chk(tx_inhibit == 1'b1, "R12 inhibit on", tx_inhibit, 1);
        tick();
        tick();
        chk(cfg_rdata[1] == 1'b1, "R11 still busy", cfg_rdata[1], 1);
        tick();
        chk(cfg_rdata[1] == 1'b0, "R11 expired", cfg_rdata[1], 0);
        chk(tx_inhibit == 1'b0, "R12 inhibit off", tx_inhibit, 0);
        wr(cfg);
        chk(cfg_rdata[2] == 1'b1, "R10 write zero keeps", cfg_rdata[2], 1);
        wr(cfg | 8'h04);
        chk(cfg_rdata[2] == 1'b0, "R10 write one clears", cfg_rdata[2], 0);
        cfg = 8'h00;
        wr(cfg);
        rx_pause(16'd2);
        chk(cfg_rdata[1] == 1'b1 && tx_inhibit == 1'b0, "R12 no inhibit when disabled",
            {cfg_rdata[1], tx_inhibit}, 2);
        tick();
        tick();
        wr(8'h04);
        full_duplex = 1'b0;
        rx_pause(16'd7);
        chk(cfg_rdata[2:1] == 2'b00, "R10 ignored in half duplex", cfg_rdata[2:1], 0);
        full_duplex = 1'b1;
        rx_pause(16'd0);
        chk(cfg_rdata[2:1] == 2'b10, "R11 zero time", cfg_rdata[2:1], 2);

        idle(4);
        chk(exp_q.size() == 0, "R5 final queue", exp_q.size(), 0);
        finish_sim();
    end
endmodule